// File: doc/BRIEF.md
# Bus I/O Port Decoder and Interface

This block sits on a simple processor bus as a slave. It watches a 16-bit address, separate read and write strobes and an I/O-versus-memory qualifier. From these it decides whether the current cycle belongs to memory or to the I/O ports, and then picks one of four input sources and one of four output registers from the two lowest address bits. The selected source is steered onto a read-data output, and an output enable marks the cycle as one the block is driving. A write to a selected output register is captured on the clock edge. Memory-select outputs tell the memory side when a cycle is its own, so that only one side ever drives read data.

A parameter picks how the address is decoded. In the memory-mapped variant the top 1 KiB of the address space (0xFC00 to 0xFFFF) is I/O space, and the port addresses are compared on every address bit. In the separate-space variant the qualifier line alone splits memory from I/O, and only the low address byte is compared. Electrical details such as tri-state drivers are left to the pads: read data comes out as a plain output with a separate enable.

Top module: `bus_io_port`

## Requirements
- R1: With MAP_MODE memory-mapped, addresses 0xFC00 through 0xFFFF are I/O cycles. mem_rd equals rd and mem_wr equals wr for addresses below 0xFC00, and both stay 0 for any address in the I/O window. io_m has no effect.
- R2: With MAP_MODE memory-mapped, port n (n = 0..3) sits at address 0xFC00 + n and all 16 address bits are compared. Addresses 0xFC04 to 0xFFFF, and addresses that differ in any upper bit (for example 0x7C00, 0xFD01, 0x0002), select no port.
- R3: With MAP_MODE separate, io_m = 1 marks an I/O cycle and io_m = 0 a memory cycle. No source enable and no destination enable asserts while io_m is 0. mem_rd = rd AND NOT io_m, and mem_wr = wr AND NOT io_m.
- R4: With MAP_MODE separate, only address bits 7:0 are decoded. Port n sits at low byte 0x00 + n whatever addr[15:8] holds. Low bytes 0x04 to 0xFF select no port.
- R5: The port index is addr[1:0], decoded one of four, and bit n of an enable vector belongs to port n. Sources and destinations have separate decode paths, so a read and a write in the same cycle each enable their own port.
- R6: src_rd_en[n] is 1 in the same cycle exactly when port n is matched and rd is 1. It is 0 otherwise, and at most one bit is set.
- R7: When src_rd_en[n] is set, rdata equals src_data[8n+7:8n] and rdata_oe is 1. When no source is enabled, rdata_oe is 0 and rdata is 0x00. rdata_oe is never 1 in a cycle where mem_rd is 1.
- R8: dst_wr_en[n] is 1 exactly when port n is matched and wr is 1. On the rising clock edge where dst_wr_en[n] is 1, dst_q[8n+7:8n] loads wdata. Every register that is not enabled keeps its value, including on writes that match no port.
- R9: A synchronous reset (rst high at a rising edge) clears all four output registers to 0x00, and this takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Bus address |
| wdata | input | 8 | Write data from the bus master |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| io_m | input | 1 | 1 = I/O cycle, 0 = memory cycle (separate mode only) |
| src_data | input | 32 | Four 8-bit input sources; port n in bits 8n+7:8n |
| rdata | output | 8 | Read data from the selected source, 0 when none |
| rdata_oe | output | 1 | Block is driving read data this cycle |
| src_rd_en | output | 4 | Per-port source read enable |
| dst_wr_en | output | 4 | Per-port destination write enable |
| dst_q | output | 32 | Four 8-bit output registers; port n in bits 8n+7:8n |
| mem_rd | output | 1 | Read belongs to memory |
| mem_wr | output | 1 | Write belongs to memory |

## Verification
The assertions assume that addr, the strobes, io_m and wdata settle between clock edges and are valid at each rising edge. They also assume that rd and wr may be high together, since nothing in the block forbids it. The stimulus therefore changes inputs only just after a rising edge and compares just before the next one. It drives both strobe values freely, including at once, and toggles io_m even for the memory-mapped instance, where it must be ignored. Addresses are drawn with a bias toward the port slots, the edge of the I/O window and aliases that differ only in upper bits, so that the full-versus-reduced decode contrast between the two instances is exercised on the same bus traffic.

// File: rtl/bio_pkg.sv
package bio_pkg;

   typedef enum logic {
      BIO_MAP_MEMORY   = 1'b0,
      BIO_MAP_SEPARATE = 1'b1
   } bio_map_e;

endpackage

// File: rtl/bio_region_decode.sv
module bio_region_decode
   import bio_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter int                SEL_W     = 2,
   parameter int                RED_W     = 8,
   parameter bio_map_e          MAP_MODE  = BIO_MAP_MEMORY,
   parameter logic [ADDR_W-1:0] IO_BASE   = 16'hFC00,
   parameter logic [ADDR_W-1:0] PORT_MM   = 16'hFC00,
   parameter logic [ADDR_W-1:0] PORT_SIO  = 16'h0000
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              io_m,
   output logic              io_cycle,
   output logic              port_hit,
   output logic [SEL_W-1:0]  port_idx
);

   assign port_idx = addr[SEL_W-1:0];

   generate
      if (MAP_MODE == BIO_MAP_MEMORY) begin : g_full
         logic unused_iom;
         assign unused_iom = io_m;
         assign io_cycle   = (addr >= IO_BASE);
         assign port_hit   = (addr[ADDR_W-1:SEL_W] == PORT_MM[ADDR_W-1:SEL_W]);
      end else begin : g_reduced
         logic unused_hi;
         if (RED_W < ADDR_W) begin : g_hi
            assign unused_hi = ^addr[ADDR_W-1:RED_W];
         end else begin : g_nohi
            assign unused_hi = 1'b0;
         end
         assign io_cycle = io_m;
         assign port_hit = io_m &&
                           (addr[RED_W-1:SEL_W] == PORT_SIO[RED_W-1:SEL_W]);
      end
   endgenerate

endmodule

// File: rtl/bio_strobe_decode.sv
module bio_strobe_decode #(
   parameter int NUM_PORTS = 4,
   parameter int SEL_W     = 2
) (
   input  logic                 hit,
   input  logic                 strobe,
   input  logic [SEL_W-1:0]     idx,
   output logic [NUM_PORTS-1:0] en
);

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         assign en[p] = hit && strobe && (idx == SEL_W'(p));
      end
   endgenerate

   always_comb begin
      assert_strobe_onehot_R5: assert ($onehot0(en));
   end

endmodule

// File: rtl/bio_read_path.sv
module bio_read_path #(
   parameter int NUM_PORTS = 4,
   parameter int DATA_W    = 8
) (
   input  logic [NUM_PORTS*DATA_W-1:0] src_data,
   input  logic [NUM_PORTS-1:0]        en,
   output logic [DATA_W-1:0]           rdata,
   output logic                        oe
);

   always_comb begin
      rdata = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         rdata = rdata | (src_data[p*DATA_W +: DATA_W] & {DATA_W{en[p]}});
      end
   end

   assign oe = |en;

endmodule

// File: rtl/bio_out_bank.sv
module bio_out_bank #(
   parameter int NUM_PORTS = 4,
   parameter int DATA_W    = 8
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [NUM_PORTS-1:0]        en,
   input  logic [DATA_W-1:0]           wdata,
   output logic [NUM_PORTS*DATA_W-1:0] q
);

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_reg
         logic [DATA_W-1:0] r;
         always_ff @(posedge clk) begin
            if (rst)        r <= '0;
            else if (en[p]) r <= wdata;
         end
         assign q[p*DATA_W +: DATA_W] = r;

         assert_capture_R8: assert property (@(posedge clk) disable iff (rst)
            (en[p] && !rst) |=> (q[p*DATA_W +: DATA_W] == $past(wdata)));
      end
   endgenerate

   assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (!rst && (en == '0)) |=> $stable(q));

   assert_reset_clear_R9: assert property (@(posedge clk)
      rst |=> (q == '0));

endmodule

// File: rtl/bus_io_port.sv
module bus_io_port
   import bio_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter int                DATA_W    = 8,
   parameter int                NUM_PORTS = 4,
   parameter int                RED_W     = 8,
   parameter bio_map_e          MAP_MODE  = BIO_MAP_MEMORY,
   parameter logic [ADDR_W-1:0] IO_BASE   = 16'hFC00,
   parameter logic [ADDR_W-1:0] PORT_MM   = 16'hFC00,
   parameter logic [ADDR_W-1:0] PORT_SIO  = 16'h0000
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [DATA_W-1:0]           wdata,
   input  logic                        rd,
   input  logic                        wr,
   input  logic                        io_m,
   input  logic [NUM_PORTS*DATA_W-1:0] src_data,
   output logic [DATA_W-1:0]           rdata,
   output logic                        rdata_oe,
   output logic [NUM_PORTS-1:0]        src_rd_en,
   output logic [NUM_PORTS-1:0]        dst_wr_en,
   output logic [NUM_PORTS*DATA_W-1:0] dst_q,
   output logic                        mem_rd,
   output logic                        mem_wr
);

   localparam int SEL_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

   initial begin
      assert_param_ports: assert (NUM_PORTS == (1 << SEL_W))
         else $error("NUM_PORTS must be a power of two");
      assert_param_reduced: assert (RED_W > SEL_W && RED_W <= ADDR_W)
         else $error("RED_W out of range");
      assert_param_data: assert (DATA_W > 0)
         else $error("DATA_W must be positive");
   end

   logic             io_cycle;
   logic             port_hit;
   logic [SEL_W-1:0] port_idx;

   bio_region_decode #(
      .ADDR_W   (ADDR_W),
      .SEL_W    (SEL_W),
      .RED_W    (RED_W),
      .MAP_MODE (MAP_MODE),
      .IO_BASE  (IO_BASE),
      .PORT_MM  (PORT_MM),
      .PORT_SIO (PORT_SIO)
   ) i_region (
      .addr     (addr),
      .io_m     (io_m),
      .io_cycle (io_cycle),
      .port_hit (port_hit),
      .port_idx (port_idx)
   );

   bio_strobe_decode #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) i_src_dec (
      .hit    (port_hit),
      .strobe (rd),
      .idx    (port_idx),
      .en     (src_rd_en)
   );

   bio_strobe_decode #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) i_dst_dec (
      .hit    (port_hit),
      .strobe (wr),
      .idx    (port_idx),
      .en     (dst_wr_en)
   );

   bio_read_path #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) i_rpath (
      .src_data (src_data),
      .en       (src_rd_en),
      .rdata    (rdata),
      .oe       (rdata_oe)
   );

   bio_out_bank #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) i_bank (
      .clk   (clk),
      .rst   (rst),
      .en    (dst_wr_en),
      .wdata (wdata),
      .q     (dst_q)
   );

   assign mem_rd = rd && !io_cycle;
   assign mem_wr = wr && !io_cycle;

   assert_src_needs_rd_R6: assert property (@(posedge clk) disable iff (rst)
      (src_rd_en != '0) |-> rd);

   assert_dst_needs_wr_R8: assert property (@(posedge clk) disable iff (rst)
      (dst_wr_en != '0) |-> wr);

   assert_single_driver_R7: assert property (@(posedge clk) disable iff (rst)
      mem_rd |-> !rdata_oe);

   assert_idle_bus_zero_R7: assert property (@(posedge clk) disable iff (rst)
      (src_rd_en == '0) |-> (rdata == '0 && !rdata_oe));

   assert_no_io_in_memory_R1: assert property (@(posedge clk) disable iff (rst)
      (mem_rd || mem_wr) |-> (src_rd_en == '0 && dst_wr_en == '0));

   generate
      if (MAP_MODE == BIO_MAP_SEPARATE) begin : g_sio_chk
         assert_no_select_mem_R3: assert property (@(posedge clk) disable iff (rst)
            !io_m |-> (src_rd_en == '0 && dst_wr_en == '0));
      end
   endgenerate

endmodule

// File: tb/test_bus_io_port.sv
`timescale 1ns/1ps
module test_bus_io_port;
   import bio_pkg::*;

   logic        clk = 1'b0;
   logic        rst;
   logic [15:0] addr;
   logic [7:0]  wdata;
   logic        rd, wr, io_m;
   logic [31:0] src_data;

   logic [7:0]  rdata_a, rdata_b;
   logic        oe_a, oe_b;
   logic [3:0]  sen_a, sen_b, den_a, den_b;
   logic [31:0] q_a, q_b;
   logic        mrd_a, mrd_b, mwr_a, mwr_b;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   logic [7:0] m_a [4];
   logic [7:0] m_b [4];

   always #2.5 clk = ~clk;

   bus_io_port #(.MAP_MODE(BIO_MAP_MEMORY)) i_bus_io_port (
      .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .rd(rd), .wr(wr),
      .io_m(io_m), .src_data(src_data), .rdata(rdata_a), .rdata_oe(oe_a),
      .src_rd_en(sen_a), .dst_wr_en(den_a), .dst_q(q_a),
      .mem_rd(mrd_a), .mem_wr(mwr_a));

   bus_io_port #(.MAP_MODE(BIO_MAP_SEPARATE)) i_bus_io_port_sio (
      .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .rd(rd), .wr(wr),
      .io_m(io_m), .src_data(src_data), .rdata(rdata_b), .rdata_oe(oe_b),
      .src_rd_en(sen_b), .dst_wr_en(den_b), .dst_q(q_b),
      .mem_rd(mrd_b), .mem_wr(mwr_b));

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s t=%0t addr=%h rd=%b wr=%b io_m=%b actual=%h expected=%h",
                  tag, $time, addr, rd, wr, io_m, act, exp);
      end
   endtask

   // Compare both instances against the behavioural model, then advance.
   task automatic step(logic r_st, logic [15:0] a, logic r, logic w,
                       logic [7:0] d, logic iom);
      logic       hit_a, hit_b, io_a;
      logic [1:0] sel;
      logic [3:0] es_a, es_b, ed_a, ed_b;
      logic [7:0] src_sel;
      rst = r_st; addr = a; rd = r; wr = w; wdata = d; io_m = iom;
      src_data = $urandom;
      @(negedge clk);
      sel     = a[1:0];
      src_sel = src_data[sel*8 +: 8];
      // R1 R2: top 1 KiB is I/O, ports at 0xFC00..0xFC03 with full compare
      io_a  = (a >= 16'hFC00);
      hit_a = (a[15:2] == 14'h3F00);
      // R3 R4: io_m qualifies, only the low byte is compared
      hit_b = iom && (a[7:2] == 6'd0);
      es_a = (hit_a && r) ? (4'b0001 << sel) : 4'b0000;
      ed_a = (hit_a && w) ? (4'b0001 << sel) : 4'b0000;
      es_b = (hit_b && r) ? (4'b0001 << sel) : 4'b0000;
      ed_b = (hit_b && w) ? (4'b0001 << sel) : 4'b0000;

      chk("R1 mem_rd (mapped)", 32'(mrd_a), 32'(r && !io_a));
      chk("R1 mem_wr (mapped)", 32'(mwr_a), 32'(w && !io_a));
      chk("R3 mem_rd (separate)", 32'(mrd_b), 32'(r && !iom));
      chk("R3 mem_wr (separate)", 32'(mwr_b), 32'(w && !iom));
      chk("R2 R5 R6 src_rd_en (mapped)", 32'(sen_a), 32'(es_a));
      chk("R4 R5 R6 src_rd_en (separate)", 32'(sen_b), 32'(es_b));
      chk("R2 R5 R8 dst_wr_en (mapped)", 32'(den_a), 32'(ed_a));
      chk("R3 R4 R8 dst_wr_en (separate)", 32'(den_b), 32'(ed_b));
      chk("R7 rdata (mapped)", 32'(rdata_a), (es_a != 0) ? 32'(src_sel) : 32'd0);
      chk("R7 rdata_oe (mapped)", 32'(oe_a), 32'(es_a != 0));
      chk("R7 rdata (separate)", 32'(rdata_b), (es_b != 0) ? 32'(src_sel) : 32'd0);
      chk("R7 rdata_oe (separate)", 32'(oe_b), 32'(es_b != 0));
      chk("R8 R9 dst_q (mapped)", q_a, {m_a[3], m_a[2], m_a[1], m_a[0]});
      chk("R8 R9 dst_q (separate)", q_b, {m_b[3], m_b[2], m_b[1], m_b[0]});

      // register model for the coming edge; R9 reset wins over a write
      if (r_st) begin
         for (int p = 0; p < 4; p++) begin m_a[p] = 8'h00; m_b[p] = 8'h00; end
      end else begin
         if (hit_a && w) m_a[sel] = d;
         if (hit_b && w) m_b[sel] = d;
      end
      @(posedge clk);
      #1;
   endtask

   function automatic logic [15:0] pick_addr();
      logic [15:0] a;
      case ($urandom_range(0, 7))
         0, 1:    a = 16'hFC00 | 16'($urandom_range(0, 3));
         2:       a = 16'hFC00 | 16'($urandom_range(0, 1023));
         3:       a = 16'hFBFC | 16'($urandom_range(0, 3));
         4, 5:    a = {8'($urandom), 6'd0, 2'($urandom)};
         default: a = 16'($urandom);
      endcase
      return a;
   endfunction

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int p = 0; p < 4; p++) begin m_a[p] = 8'h00; m_b[p] = 8'h00; end
      // R9: reset state, including a write attempt during reset
      step(1'b1, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b0);
      step(1'b1, 16'hFC01, 1'b0, 1'b1, 8'hAA, 1'b1);
      step(1'b1, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b0);

      // R2 R4 R8: write each port in both decode schemes
      for (int p = 0; p < 4; p++)
         step(1'b0, 16'hFC00 + 16'(p), 1'b0, 1'b1, 8'h10 + 8'(p), 1'b1);
      // R5 R6 R7: read back every source
      for (int p = 0; p < 4; p++)
         step(1'b0, 16'hFC00 + 16'(p), 1'b1, 1'b0, 8'h00, 1'b1);
      // R2: unused I/O window slots and near-miss aliases select nothing
      step(1'b0, 16'hFC04, 1'b1, 1'b1, 8'h5A, 1'b1);
      step(1'b0, 16'hFFFF, 1'b1, 1'b1, 8'h5B, 1'b1);
      step(1'b0, 16'hFD01, 1'b1, 1'b1, 8'h5C, 1'b0);
      step(1'b0, 16'h7C00, 1'b1, 1'b1, 8'h5D, 1'b1);
      // R1: just below the window is memory
      step(1'b0, 16'hFBFF, 1'b1, 1'b1, 8'h5E, 1'b1);
      // R3: io_m low blocks the separate instance; R1: mapped ignores io_m
      step(1'b0, 16'hFC02, 1'b1, 1'b1, 8'h66, 1'b0);
      step(1'b0, 16'h0002, 1'b1, 1'b1, 8'h67, 1'b0);
      // R4: upper byte ignored in separate mode
      step(1'b0, 16'h3703, 1'b0, 1'b1, 8'h77, 1'b1);
      step(1'b0, 16'hA503, 1'b1, 1'b0, 8'h00, 1'b1);
      step(1'b0, 16'h0004, 1'b1, 1'b1, 8'h78, 1'b1);
      // R5: read and write together hit the same decoded index
      step(1'b0, 16'hFC01, 1'b1, 1'b1, 8'h99, 1'b1);
      step(1'b0, 16'hFC01, 1'b1, 1'b0, 8'h00, 1'b1);

      for (int i = 0; i < 600; i++)
         step(1'b0, pick_addr(), 1'($urandom), 1'($urandom), 8'($urandom),
              1'($urandom));

      // R9: reset mid-run while a write is presented
      step(1'b1, 16'hFC00, 1'b0, 1'b1, 8'hEE, 1'b1);
      step(1'b0, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b0);
      for (int i = 0; i < 200; i++)
         step(1'b0, pick_addr(), 1'($urandom), 1'($urandom), 8'($urandom),
              1'($urandom));

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule